// File: doc/BRIEF.md
# Multi-pack header probe and bank-select controller

This block works out whether a plugged-in cartridge holds two games in two banks. On a probe command it reads four header bytes from the ROM through a simple request/acknowledge bus. Two of the bytes must be nonzero, and those two are the values that select bank 0 and bank 1. The other two bytes must be zero. If all four checks pass, the block raises its multi-pack flag, reports both select values, and derives the total image size from the pair. A pair it does not recognise gives the largest size and raises a warning.

Once a multi-pack is known, a select command chooses the lower or upper half of the image. The block writes the matching select value to the control address in the CPU-internal window. Write-enable is held for a fixed, parameterised number of clock cycles. The block also reports the active bank and the base address from which the host must read that half. The host that streams out the ROM contents drives the commands. It must wait while `busy_o` is high.

Top module: `mpk_ctrl`

## Requirements
- R1: After reset, `busy_o`, `bus_req_o`, `bus_we_o`, `multi_o`, `warn_o` and `cur_bank_o` are 0, and `size_o`, both bank values and `base_addr_o` are 0.
- R2: A probe issues ROM reads (`bus_int_o`=0, `bus_we_o`=0) in this fixed order: 0x3FFC, 0x3FFD, 0x3FFB, 0x3FFF. Each read ends on the cycle in which `bus_ack_i` is high, and `bus_rdata_i` is taken on that cycle.
- R3: The probe stops at the first failed check, with no further reads. A failed check is a zero byte at 0x3FFC or 0x3FFD, or a nonzero byte at 0x3FFB or 0x3FFF. After a failed probe, `multi_o`=0, `warn_o`=0, `size_o`=0, and both bank values read 0.
- R4: When all four checks pass, `multi_o`=1. `bank0_val_o` equals the byte at 0x3FFC and `bank1_val_o` equals the byte at 0x3FFD.
- R5: The pair bank0=0x28, bank1=0x2E gives `size_o`=2^(ADDR_W-1) bytes (0x200000 when ADDR_W=22), with `warn_o`=0.
- R6: The pair bank0=0x20, bank1=0x31 gives `size_o`=2^ADDR_W bytes (0x400000), with `warn_o`=0.
- R7: Any other passing pair gives `size_o`=2^ADDR_W and `warn_o`=1.
- R8: A select command with `sel_bank_i`=b writes once to address 0xFFFF in the internal window (`bus_int_o`=1). The data is `bank1_val_o` when b=1 and `bank0_val_o` when b=0. `bus_we_o` stays high for exactly WE_CYCLES consecutive cycles.
- R9: When the write ends, `cur_bank_o`=b. `base_addr_o` is 2^(ADDR_W-1) when b=1 and 0 when b=0.
- R10: A select command while `multi_o`=0 is ignored: no bus request, `busy_o` stays 0, and `cur_bank_o` does not change.
- R11: Probe and select commands that arrive while `busy_o`=1 are ignored. If both arrive together while idle, the probe wins.
- R12: An accepted probe clears `multi_o`, the bank values and `cur_bank_o` on the cycle after the command.
- R13: `busy_o` rises on the cycle after an accepted command and falls on the cycle after the last bus access ends. `bus_req_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| probe_i | input | 1 | Start a header probe |
| sel_i | input | 1 | Start a bank-select write |
| sel_bank_i | input | 1 | Bank to select: 0 lower, 1 upper |
| busy_o | output | 1 | Command in progress |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Write strobe, held for the timed window |
| bus_int_o | output | 1 | 1 = CPU-internal window, 0 = ROM |
| bus_addr_o | output | ADDR_W | Access address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data |
| bus_ack_i | input | 1 | Read data valid, ends the read |
| multi_o | output | 1 | Multi-pack detected |
| size_o | output | ADDR_W+1 | Total image size in bytes, 0 if not multi-pack |
| bank0_val_o | output | 8 | Lower-half select value |
| bank1_val_o | output | 8 | Upper-half select value |
| warn_o | output | 1 | Unknown select pair, size assumed maximal |
| cur_bank_o | output | 1 | Bank last selected |
| base_addr_o | output | ADDR_W | Read base of the selected half |

## Verification
The bench builds the block with ADDR_W=22 and WE_CYCLES=4. The short write window keeps each select sequence to a few cycles, so the sweep can run a full select round trip for every header combination that passes. Each header byte takes values from a small set: zero, each of the known select codes, and an unknown nonzero code. This gives 64 header combinations. Together they hit every early-stop point of the probe, both known size pairs and the warning path. The expected read order, flags, size, write data and write length are computed from the header bytes alone.

// File: rtl/mpk_pkg.sv
package mpk_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [15:0] HDR_SEL0_ADDR = 16'h3FFC;
  localparam logic [15:0] HDR_SEL1_ADDR = 16'h3FFD;
  localparam logic [15:0] HDR_PAD0_ADDR = 16'h3FFB;
  localparam logic [15:0] HDR_PAD1_ADDR = 16'h3FFF;
  localparam logic [15:0] BANK_CTRL_ADDR = 16'hFFFF;

  localparam logic [7:0] PAIR_HALF_B0 = 8'h28;
  localparam logic [7:0] PAIR_HALF_B1 = 8'h2E;
  localparam logic [7:0] PAIR_FULL_B0 = 8'h20;
  localparam logic [7:0] PAIR_FULL_B1 = 8'h31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL0, ST_SEL1, ST_PAD0, ST_PAD1, ST_SWITCH
  } ctrl_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_READ, SQ_WRITE
  } seq_state_e;
endpackage

// File: rtl/mpk_size_decode.sv
module mpk_size_decode
  import mpk_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  localparam int unsigned SIZE_W = ADDR_W + 1
) (
  input  logic [BYTE_W-1:0] sel0_i,
  input  logic [BYTE_W-1:0] sel1_i,
  output logic [SIZE_W-1:0] size_o,
  output logic              warn_o
);
  localparam logic [SIZE_W-1:0] SIZE_HALF = SIZE_W'(1) << (ADDR_W - 1);
  localparam logic [SIZE_W-1:0] SIZE_FULL = SIZE_W'(1) << ADDR_W;

  logic is_half, is_full;

  always_comb begin
    is_half = (sel0_i == PAIR_HALF_B0) && (sel1_i == PAIR_HALF_B1);
    is_full = (sel0_i == PAIR_FULL_B0) && (sel1_i == PAIR_FULL_B1);
    size_o  = is_half ? SIZE_HALF : SIZE_FULL;
    warn_o  = !is_half && !is_full;
  end
endmodule

// File: rtl/mpk_bus_seq.sv
module mpk_bus_seq
  import mpk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned WE_CYCLES = 37,
  localparam int unsigned CNT_W    = $clog2(WE_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              write_i,
  input  logic              int_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_int_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BYTE_W-1:0] bus_wdata_o,
  input  logic [BYTE_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i
);
  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              int_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      int_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (go_i) begin
          state_q <= write_i ? SQ_WRITE : SQ_READ;
          addr_q  <= addr_i;
          int_q   <= int_i;
          wdata_q <= write_i ? wdata_i : '0;
          cnt_q   <= CNT_W'(WE_CYCLES - 1);
        end
        SQ_READ: if (bus_ack_i) begin
          state_q <= SQ_IDLE;
          addr_q  <= '0;
          int_q   <= 1'b0;
        end
        SQ_WRITE: begin
          if (cnt_q == '0) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            int_q   <= 1'b0;
            wdata_q <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (state_q != SQ_IDLE);
  assign bus_we_o    = (state_q == SQ_WRITE);
  assign bus_int_o   = int_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign done_o      = ((state_q == SQ_READ) && bus_ack_i) ||
                       ((state_q == SQ_WRITE) && (cnt_q == '0));
  assign rdata_o     = bus_rdata_i;
endmodule

// File: rtl/mpk_ctrl.sv
module mpk_ctrl
  import mpk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned WE_CYCLES = 37,
  localparam int unsigned SIZE_W   = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              probe_i,
  input  logic              sel_i,
  input  logic              sel_bank_i,
  output logic              busy_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_int_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              multi_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [7:0]        bank0_val_o,
  output logic [7:0]        bank1_val_o,
  output logic              warn_o,
  output logic              cur_bank_o,
  output logic [ADDR_W-1:0] base_addr_o
);
  localparam logic [ADDR_W-1:0] UPPER_BASE = ADDR_W'(1) << (ADDR_W - 1);

  ctrl_state_e       state_q;
  logic [BYTE_W-1:0] sel0_q, sel1_q;
  logic              multi_q, cur_q, pick_q;

  logic              go, wr, done;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] wdata, rdata;
  logic [SIZE_W-1:0] dec_size;
  logic              dec_warn;

  always_comb begin
    go    = (state_q != ST_IDLE);
    wr    = (state_q == ST_SWITCH);
    wdata = pick_q ? sel1_q : sel0_q;
    unique case (state_q)
      ST_SEL0:   addr = ADDR_W'(HDR_SEL0_ADDR);
      ST_SEL1:   addr = ADDR_W'(HDR_SEL1_ADDR);
      ST_PAD0:   addr = ADDR_W'(HDR_PAD0_ADDR);
      ST_PAD1:   addr = ADDR_W'(HDR_PAD1_ADDR);
      ST_SWITCH: addr = ADDR_W'(BANK_CTRL_ADDR);
      default:   addr = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel0_q  <= '0;
      sel1_q  <= '0;
      multi_q <= 1'b0;
      cur_q   <= 1'b0;
      pick_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (probe_i) begin
            state_q <= ST_SEL0;
            multi_q <= 1'b0;
            sel0_q  <= '0;
            sel1_q  <= '0;
            cur_q   <= 1'b0;
          end else if (sel_i && multi_q) begin
            state_q <= ST_SWITCH;
            pick_q  <= sel_bank_i;
          end
        end
        ST_SEL0: if (done) begin
          if (rdata == '0) state_q <= ST_IDLE;
          else begin
            sel0_q  <= rdata;
            state_q <= ST_SEL1;
          end
        end
        ST_SEL1: if (done) begin
          if (rdata == '0) begin
            sel0_q  <= '0;
            state_q <= ST_IDLE;
          end else begin
            sel1_q  <= rdata;
            state_q <= ST_PAD0;
          end
        end
        ST_PAD0: if (done) begin
          if (rdata != '0) begin
            sel0_q  <= '0;
            sel1_q  <= '0;
            state_q <= ST_IDLE;
          end else state_q <= ST_PAD1;
        end
        ST_PAD1: if (done) begin
          if (rdata != '0) begin
            sel0_q <= '0;
            sel1_q <= '0;
          end else multi_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_SWITCH: if (done) begin
          cur_q   <= pick_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  mpk_bus_seq #(.ADDR_W(ADDR_W), .WE_CYCLES(WE_CYCLES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .write_i    (wr),
    .int_i      (wr),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .done_o     (done),
    .rdata_o    (rdata),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_int_o  (bus_int_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i),
    .bus_ack_i  (bus_ack_i)
  );

  mpk_size_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel0_i(sel0_q),
    .sel1_i(sel1_q),
    .size_o(dec_size),
    .warn_o(dec_warn)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign multi_o     = multi_q;
  assign size_o      = multi_q ? dec_size : '0;
  assign warn_o      = multi_q && dec_warn;
  assign bank0_val_o = multi_q ? sel0_q : '0;
  assign bank1_val_o = multi_q ? sel1_q : '0;
  assign cur_bank_o  = cur_q;
  assign base_addr_o = cur_q ? UPPER_BASE : '0;
endmodule

// File: rtl/mpk_ctrl_chk.sv
module mpk_ctrl_chk #(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned WE_CYCLES = 37,
  localparam int unsigned SIZE_W   = ADDR_W + 1,
  localparam int unsigned LEN_W    = $clog2(WE_CYCLES + 2) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic              bus_int_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              multi_o,
  input logic [SIZE_W-1:0] size_o,
  input logic              warn_o,
  input logic [7:0]        bank0_val_o,
  input logic [7:0]        bank1_val_o,
  input logic              cur_bank_o,
  input logic [ADDR_W-1:0] base_addr_o
);
  localparam logic [SIZE_W-1:0] SIZE_FULL  = SIZE_W'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] UPPER_BASE = ADDR_W'(1) << (ADDR_W - 1);

  logic [LEN_W-1:0] we_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_len_q <= '0;
    else if (bus_we_o) we_len_q <= we_len_q + 1'b1;
    else we_len_q <= '0;
  end

  AST_WE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_we_o) |-> (we_len_q == LEN_W'(WE_CYCLES))); // R8

  AST_WE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> (bus_int_o && bus_addr_o == ADDR_W'(16'hFFFF))); // R8

  AST_READ_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o) |-> !bus_int_o); // R2

  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o); // R13

  AST_FAIL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !multi_o |-> (size_o == '0 && !warn_o && bank0_val_o == '0 && bank1_val_o == '0)); // R3

  AST_WARN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> (size_o == SIZE_FULL)); // R7

  AST_UPPER_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_bank_o |-> (base_addr_o == UPPER_BASE)); // R9

  AST_IDLE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !multi_o) |=> !bus_we_o); // R10
endmodule

bind mpk_ctrl mpk_ctrl_chk #(.ADDR_W(ADDR_W), .WE_CYCLES(WE_CYCLES)) u_mpk_ctrl_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .bus_req_o  (bus_req_o),
  .bus_we_o   (bus_we_o),
  .bus_int_o  (bus_int_o),
  .bus_addr_o (bus_addr_o),
  .multi_o    (multi_o),
  .size_o     (size_o),
  .warn_o     (warn_o),
  .bank0_val_o(bank0_val_o),
  .bank1_val_o(bank1_val_o),
  .cur_bank_o (cur_bank_o),
  .base_addr_o(base_addr_o)
);

// File: tb/mpk_ctrl_bench.sv
module mpk_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 22;
  localparam int WE_CYCLES  = 4;
  localparam int SIZE_W     = ADDR_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic probe = 1'b0, sel = 1'b0, sel_bank = 1'b0;
  logic busy, bus_req, bus_we, bus_int, bus_ack = 1'b0;
  logic [ADDR_W-1:0] bus_addr, base_addr;
  logic [7:0] bus_wdata, bus_rdata = 8'h00, b0_out, b1_out;
  logic multi, warn, cur_bank;
  logic [SIZE_W-1:0] size;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpk_ctrl #(.ADDR_W(ADDR_W), .WE_CYCLES(WE_CYCLES)) u_mpk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .probe_i(probe), .sel_i(sel), .sel_bank_i(sel_bank),
    .busy_o(busy), .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_int_o(bus_int),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_ack_i(bus_ack), .multi_o(multi), .size_o(size), .bank0_val_o(b0_out),
    .bank1_val_o(b1_out), .warn_o(warn), .cur_bank_o(cur_bank), .base_addr_o(base_addr)
  );

  int checks = 0, errors = 0;
  logic [7:0] h_b0, h_b1, h_z0, h_z1;
  logic [ADDR_W-1:0] rd_log [8];
  int rd_n = 0, rd_int_bad = 0, wr_n = 0, we_run = 0, we_len = 0;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;
  logic wr_int;

  function automatic logic [7:0] rom(input logic [ADDR_W-1:0] a);
    case (a)
      22'h3FFC: return h_b0;
      22'h3FFD: return h_b1;
      22'h3FFB: return h_z0;
      22'h3FFF: return h_z1;
      default:  return a[7:0] ^ 8'hA5;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] exp_rd(input int k);
    case (k)
      0: return 22'h3FFC;
      1: return 22'h3FFD;
      2: return 22'h3FFB;
      default: return 22'h3FFF;
    endcase
  endfunction

  // bus model: one-cycle read latency, write strobe length measured
  always @(negedge clk) begin
    if (bus_req && !bus_we && !bus_ack) begin
      bus_ack = 1'b1;
      bus_rdata = rom(bus_addr);
      if (rd_n < 8) rd_log[rd_n] = bus_addr;
      rd_n++;
      if (bus_int) rd_int_bad++;
    end else begin
      bus_ack = 1'b0;
    end
    if (bus_we) begin
      we_run++;
      wr_addr = bus_addr;
      wr_data = bus_wdata;
      wr_int  = bus_int;
    end else if (we_run != 0) begin
      we_len = we_run;
      we_run = 0;
      wr_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 200 && busy; g++) step();
  endtask

  task automatic run_probe();
    rd_n = 0;
    probe = 1'b1;
    step();
    probe = 1'b0;
    chk(busy == 1'b1, "R13", "busy after probe", busy, 1);
    chk(multi == 1'b0 && cur_bank == 1'b0, "R12", "cleared at probe start",
        {multi, cur_bank}, 0);
    wait_idle();
  endtask

  task automatic do_sel(input logic b);
    sel = 1'b1;
    sel_bank = b;
    step();
    sel = 1'b0;
    wait_idle();
  endtask

  function automatic logic [7:0] pick(input int set, input int i);
    case (set)
      0: case (i) 0: return 8'h00; 1: return 8'h28; 2: return 8'h20; default: return 8'h7F; endcase
      1: case (i) 0: return 8'h00; 1: return 8'h2E; 2: return 8'h31; default: return 8'h01; endcase
      2: return (i == 0) ? 8'h00 : 8'h5A;
      default: return (i == 0) ? 8'h00 : 8'h80;
    endcase
  endfunction

  task automatic run_all();
    int n_exp, wn;
    logic e_multi, e_warn;
    logic [SIZE_W-1:0] e_size;
    repeat (3) step();
    chk(!busy && !bus_req && !bus_we && !multi && !warn && !cur_bank, "R1",
        "control outputs in reset", {busy, bus_req, bus_we, multi, warn, cur_bank}, 0);
    chk(size == 0 && b0_out == 0 && b1_out == 0 && base_addr == 0, "R1",
        "data outputs in reset", size, 0);
    rst_n = 1'b1;
    step();

    // R10: select before any successful probe
    wn = wr_n;
    sel = 1'b1; sel_bank = 1'b1;
    step();
    sel = 1'b0;
    step();
    chk(!busy && !bus_req && wr_n == wn && !cur_bank, "R10", "select ignored pre-probe",
        {busy, bus_req, cur_bank}, 0);

    for (int i0 = 0; i0 < 4; i0++)
      for (int i1 = 0; i1 < 4; i1++)
        for (int i2 = 0; i2 < 2; i2++)
          for (int i3 = 0; i3 < 2; i3++) begin
            h_b0 = pick(0, i0); h_b1 = pick(1, i1);
            h_z0 = pick(2, i2); h_z1 = pick(3, i3);
            n_exp = (h_b0 == 0) ? 1 : (h_b1 == 0) ? 2 : (h_z0 != 0) ? 3 : 4;
            e_multi = (n_exp == 4) && (h_z1 == 0);
            e_size = !e_multi ? '0 :
                     (h_b0 == 8'h28 && h_b1 == 8'h2E) ? SIZE_W'(32'h200000) : SIZE_W'(32'h400000);
            e_warn = e_multi && !(h_b0 == 8'h28 && h_b1 == 8'h2E) &&
                     !(h_b0 == 8'h20 && h_b1 == 8'h31);
            wn = wr_n;
            run_probe();
            chk(rd_n == n_exp, "R3", "read count / early stop", rd_n, n_exp);
            for (int k = 0; k < n_exp && k < 8; k++)
              chk(rd_log[k] == exp_rd(k), "R2", "read order", rd_log[k], exp_rd(k));
            chk(rd_int_bad == 0 && wr_n == wn, "R2", "probe uses ROM reads only", rd_int_bad, 0);
            chk(multi == e_multi, e_multi ? "R4" : "R3", "multi flag", multi, e_multi);
            chk(b0_out == (e_multi ? h_b0 : 8'h00) && b1_out == (e_multi ? h_b1 : 8'h00),
                e_multi ? "R4" : "R3", "bank values", {b0_out, b1_out},
                e_multi ? {h_b0, h_b1} : 16'h0);
            chk(size == e_size, (e_size == SIZE_W'(32'h200000)) ? "R5" : e_warn ? "R7" : "R6",
                "size", size, e_size);
            chk(warn == e_warn, e_warn ? "R7" : "R6", "warn", warn, e_warn);
            if (e_multi) begin
              for (int b = 1; b >= 0; b--) begin
                wn = wr_n;
                do_sel(b[0]);
                chk(wr_n == wn + 1 && wr_addr == 22'h00FFFF && wr_int, "R8",
                    "control write target", wr_addr, 32'hFFFF);
                chk(wr_data == (b ? h_b1 : h_b0), "R8", "control write data",
                    wr_data, b ? h_b1 : h_b0);
                chk(we_len == WE_CYCLES, "R8", "write strobe length", we_len, WE_CYCLES);
                chk(cur_bank == b[0] && base_addr == (b ? 22'h200000 : 22'h0), "R9",
                    "active bank and base", base_addr, b ? 22'h200000 : 22'h0);
              end
            end else begin
              wn = wr_n;
              sel = 1'b1; sel_bank = 1'b1;
              step();
              sel = 1'b0;
              step();
              chk(!busy && wr_n == wn && !cur_bank, "R10", "select ignored after failed probe",
                  {busy, cur_bank}, 0);
            end
          end

    // R11: commands during a busy probe are dropped; probe wins a tie
    h_b0 = 8'h20; h_b1 = 8'h31; h_z0 = 8'h00; h_z1 = 8'h00;
    run_probe();
    do_sel(1'b1);
    chk(cur_bank == 1'b1, "R9", "upper bank set before re-probe", cur_bank, 1);
    wn = wr_n;
    rd_n = 0;
    probe = 1'b1; sel = 1'b1; sel_bank = 1'b0;
    step();
    probe = 1'b0; sel = 1'b0;
    chk(cur_bank == 1'b0 && multi == 1'b0, "R12", "re-probe clears bank state",
        {multi, cur_bank}, 0);
    step(); step();
    probe = 1'b1; sel = 1'b1;
    step();
    probe = 1'b0; sel = 1'b0;
    wait_idle();
    step(); step();
    chk(rd_n == 4 && wr_n == wn, "R11", "busy commands ignored, probe won tie", rd_n, 4);
    chk(multi && size == SIZE_W'(32'h400000) && !warn, "R6", "full pair after re-probe", size,
        32'h400000);
    chk(!busy && !bus_req, "R13", "idle after probe", {busy, bus_req}, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule